// File: doc/BRIEF.md
# SDRAM Command Sequencer (single bank at a time, closed page)

This block connects a simple request port to a four-bank, 16-bit synchronous DRAM. After reset it brings the memory up by itself. It waits for a programmable power-up time, precharges every bank, issues two refreshes and then loads the mode register. From then on it serves one request at a time. Each access is an activate followed, after the row-to-column delay, by a single-word read or write with auto-precharge. A refresh timer runs in the background and asks for an auto refresh at a fixed interval. The sequencer fits each refresh in between user accesses.

All memory timings are counted in clock cycles and set by parameters. The defaults match CAS latency 2 at 100 MHz. A user address is split into bank, row and column. A write drives its data and byte mask in the same cycle as the write command. A read returns its word with a one-cycle valid strobe once the CAS latency has passed. The data bus is split into an output, an output enable and an input, so the tristate buffer stays outside the block.

Top module: `sdram_seq`

## Requirements
- R1: After reset the block keeps `req_ready` low and issues only NOP until at least `INIT_WAIT` cycles have elapsed. It then issues, in this order: precharge with A10=1 (all banks), auto refresh, auto refresh, and mode register set. The mode word is 0x020 on A with BA=0, meaning burst length 1 (A[2:0]=000), sequential (A3=0) and CAS latency 2 (A[6:4]=010).
- R2: Commands are encoded on {cs_n, ras_n, cas_n, we_n}. The codes are: 0000 mode set, 0001 refresh, 0010 precharge, 0011 activate, 0100 write, 0101 read, 0111 NOP. `sd_cke` is always 1.
- R3: The user address maps as bank = `req_addr[22:21]`, row = `req_addr[20:9]` and column = `req_addr[8:0]`. Activate carries the bank on BA and the row on A. The read or write follows exactly `T_RCD` cycles later, with the same BA, the column on A[8:0] and A10=1 (auto-precharge).
- R4: A write drives `sd_dq_out` with the request data and sets `sd_dq_oe`=1 in the same cycle as the write command. It drives `sd_dqm` = ~`req_be`, where bit 0 masks the low byte. `sd_dq_oe` is 0 in every other cycle.
- R5: The block samples `sd_dq_in` on the clock edge that ends the cycle `CAS_LAT` cycles after the read command. It returns that word on `rd_data` with `rd_valid` high for one cycle, `CAS_LAT`+1 cycles after the read command was on the pins. Reads return in request order.
- R6: Two activates are at least `T_RC` cycles apart. The next command after a write access waits at least `T_RCD`+`T_WR`+`T_RP` cycles from its activate.
- R7: A refresh request becomes pending every `REF_INTERVAL` cycles after initialization. A pending refresh is issued before any further request is accepted, and `req_ready` stays low while one is pending.
- R8: No command other than NOP is issued within `T_RRC` cycles after an auto refresh or within `T_MRD` cycles after the mode register set.
- R9: A request is accepted on a clock edge where `req_valid` and `req_ready` are both high. The cycle after acceptance shows an activate. `req_ready` is low until that access has finished its timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be accepted this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 23 | {bank, row, column} word address |
| req_wdata | input | 16 | Write data |
| req_be | input | 2 | Byte enables for a write |
| rd_valid | output | 1 | Read data valid pulse |
| rd_data | output | 16 | Read data |
| sd_cke | output | 1 | Memory clock enable |
| sd_cs_n | output | 1 | Chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_ba | output | 2 | Bank address |
| sd_a | output | 12 | Row / column / mode address |
| sd_dqm | output | 2 | Data mask per byte lane |
| sd_dq_out | output | 16 | Data driven to memory |
| sd_dq_oe | output | 1 | Output enable for `sd_dq_out` |
| sd_dq_in | input | 16 | Data returned by memory |

## Verification
The refresh timer can expire in the same cycle in which a user request is waiting at an idle sequencer. It can also expire in the middle of an access, so that it is pending at the same moment the next request arrives. The bench provokes both by streaming back-to-back requests with `req_valid` held high across several refresh intervals. It predicts the refresh deadlines from the cycle of the mode register set. At every activate it checks that the number of refreshes already issued equals the number of deadlines that have passed. At every refresh it checks that the refresh came within one access time of its deadline. The command spacing after each refresh and the ordering of the read data are judged at the same time.

// File: rtl/sdram_seq_pkg.sv
package sdram_seq_pkg;

    localparam int BA_W   = 2;
    localparam int ROW_W  = 12;
    localparam int COL_W  = 9;
    localparam int DQ_W   = 16;
    localparam int LANES  = DQ_W / 8;
    localparam int ADDR_W = BA_W + ROW_W + COL_W;
    localparam int AP_BIT = 10;

    // {cs_n, ras_n, cas_n, we_n}
    typedef enum logic [3:0] {
        CMD_MRS = 4'b0000,
        CMD_REF = 4'b0001,
        CMD_PRE = 4'b0010,
        CMD_ACT = 4'b0011,
        CMD_WR  = 4'b0100,
        CMD_RD  = 4'b0101,
        CMD_BST = 4'b0110,
        CMD_NOP = 4'b0111
    } sd_cmd_e;

    typedef struct packed {
        sd_cmd_e              cmd;
        logic [BA_W-1:0]      ba;
        logic [ROW_W-1:0]     a;
        logic [LANES-1:0]     dqm;
        logic [DQ_W-1:0]      dq;
        logic                 oe;
    } sd_bus_t;

    typedef struct packed {
        logic                 wr;
        logic [BA_W-1:0]      ba;
        logic [ROW_W-1:0]     row;
        logic [COL_W-1:0]     col;
        logic [DQ_W-1:0]      wd;
        logic [LANES-1:0]     be;
    } sd_req_t;

    function automatic int imax(input int x, input int y);
        return (x > y) ? x : y;
    endfunction

    // burst length 1, sequential order, given CAS latency
    function automatic logic [ROW_W-1:0] mode_word(input int cl);
        logic [ROW_W-1:0] m;
        m      = '0;
        m[6:4] = 3'(cl);
        return m;
    endfunction

    function automatic sd_bus_t bus_idle();
        sd_bus_t b;
        b     = '0;
        b.cmd = CMD_NOP;
        return b;
    endfunction

endpackage

// File: rtl/sdram_seq_refresh.sv
module sdram_seq_refresh #(
    parameter int INTERVAL = 1560
) (
    input  logic clk,
    input  logic rst,
    input  logic en,
    input  logic ack,
    output logic pending
);
    localparam int CNT_W = $clog2(INTERVAL + 1);

    logic [CNT_W-1:0] cnt;
    logic             tick;

    assign tick = en && (cnt == CNT_W'(INTERVAL - 1));

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            cnt     <= '0;
            pending <= 1'b0;
        end else begin
            cnt     <= tick ? '0 : cnt + 1'b1;
            pending <= (pending && !ack) || tick;
        end
    end
endmodule

// File: rtl/sdram_seq_ctrl.sv
module sdram_seq_ctrl import sdram_seq_pkg::*; #(
    parameter int INIT_WAIT = 20000,
    parameter int T_RCD     = 2,
    parameter int T_RAS     = 5,
    parameter int T_RC      = 7,
    parameter int T_RP      = 2,
    parameter int T_RRC     = 7,
    parameter int T_MRD     = 2,
    parameter int T_WR      = 2,
    parameter int CAS_LAT   = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DQ_W-1:0]   req_wdata,
    input  logic [LANES-1:0]  req_be,
    output logic              req_ready,
    input  logic              ref_pending,
    output logic              ref_ack,
    output logic              init_done,
    output sd_bus_t           bus_nxt
);
    // cycles from activate until the next command may issue
    localparam int ACC_R   = imax(T_RC, T_RAS + T_RP);
    localparam int ACC_W   = imax(ACC_R, T_RCD + T_WR + T_RP);
    localparam int GAP_MAX = imax(INIT_WAIT, imax(ACC_W, imax(T_RRC, T_MRD)));
    localparam int GAP_W   = $clog2(GAP_MAX + 1);

    typedef enum logic [2:0] {
        ST_PWR, ST_IREF1, ST_IREF2, ST_IMRS, ST_IDLE, ST_RW
    } st_e;

    st_e              state, state_n;
    logic [GAP_W-1:0] gap, gap_n;
    sd_req_t          cur, cur_n;
    logic             free;

    assign free      = (gap == '0);
    assign init_done = (state == ST_IDLE) || (state == ST_RW);
    assign req_ready = (state == ST_IDLE) && free && !ref_pending;

    always_comb begin
        state_n = state;
        gap_n   = free ? gap : gap - 1'b1;
        cur_n   = cur;
        ref_ack = 1'b0;
        bus_nxt = bus_idle();
        if (free) begin
            unique case (state)
                ST_PWR: begin
                    bus_nxt.cmd       = CMD_PRE;
                    bus_nxt.a[AP_BIT] = 1'b1;
                    gap_n             = GAP_W'(T_RP - 1);
                    state_n           = ST_IREF1;
                end
                ST_IREF1, ST_IREF2: begin
                    bus_nxt.cmd = CMD_REF;
                    gap_n       = GAP_W'(T_RRC - 1);
                    state_n     = (state == ST_IREF1) ? ST_IREF2 : ST_IMRS;
                end
                ST_IMRS: begin
                    bus_nxt.cmd = CMD_MRS;
                    bus_nxt.a   = mode_word(CAS_LAT);
                    gap_n       = GAP_W'(T_MRD - 1);
                    state_n     = ST_IDLE;
                end
                ST_IDLE: begin
                    if (ref_pending) begin
                        bus_nxt.cmd = CMD_REF;
                        gap_n       = GAP_W'(T_RRC - 1);
                        ref_ack     = 1'b1;
                    end else if (req_valid) begin
                        cur_n.wr    = req_write;
                        cur_n.ba    = req_addr[ADDR_W-1 -: BA_W];
                        cur_n.row   = req_addr[COL_W +: ROW_W];
                        cur_n.col   = req_addr[COL_W-1:0];
                        cur_n.wd    = req_wdata;
                        cur_n.be    = req_be;
                        bus_nxt.cmd = CMD_ACT;
                        bus_nxt.ba  = cur_n.ba;
                        bus_nxt.a   = cur_n.row;
                        gap_n       = GAP_W'(T_RCD - 1);
                        state_n     = ST_RW;
                    end
                end
                ST_RW: begin
                    bus_nxt.cmd            = cur.wr ? CMD_WR : CMD_RD;
                    bus_nxt.ba             = cur.ba;
                    bus_nxt.a[COL_W-1:0]   = cur.col;
                    bus_nxt.a[AP_BIT]      = 1'b1;
                    bus_nxt.dq             = cur.wr ? cur.wd : '0;
                    bus_nxt.oe             = cur.wr;
                    bus_nxt.dqm            = cur.wr ? ~cur.be : '0;
                    gap_n                  = cur.wr ? GAP_W'(ACC_W - T_RCD - 1)
                                                    : GAP_W'(ACC_R - T_RCD - 1);
                    state_n                = ST_IDLE;
                end
                default: state_n = ST_PWR;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_PWR;
            gap   <= GAP_W'(INIT_WAIT - 1);
            cur   <= '0;
        end else begin
            state <= state_n;
            gap   <= gap_n;
            cur   <= cur_n;
        end
    end
endmodule

// File: rtl/sdram_seq_phy.sv
module sdram_seq_phy import sdram_seq_pkg::*; #(
    parameter int CAS_LAT = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  sd_bus_t          bus_nxt,
    input  logic [DQ_W-1:0]  sd_dq_in,
    output logic             sd_cke,
    output logic             sd_cs_n,
    output logic             sd_ras_n,
    output logic             sd_cas_n,
    output logic             sd_we_n,
    output logic [BA_W-1:0]  sd_ba,
    output logic [ROW_W-1:0] sd_a,
    output logic [LANES-1:0] sd_dqm,
    output logic [DQ_W-1:0]  sd_dq_out,
    output logic             sd_dq_oe,
    output logic             rd_valid,
    output logic [DQ_W-1:0]  rd_data
);
    sd_bus_t          pin_q;
    logic [CAS_LAT:0] rd_sh;

    always_ff @(posedge clk) begin
        if (rst) begin
            pin_q <= bus_idle();
            rd_sh <= '0;
        end else begin
            pin_q <= bus_nxt;
            rd_sh <= {rd_sh[CAS_LAT-1:0], bus_nxt.cmd == CMD_RD};
        end
    end

    // one capture register per byte lane
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        always_ff @(posedge clk) begin
            if (rst) begin
                rd_data[g*8 +: 8] <= '0;
            end else if (rd_sh[CAS_LAT]) begin
                rd_data[g*8 +: 8] <= sd_dq_in[g*8 +: 8];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) rd_valid <= 1'b0;
        else     rd_valid <= rd_sh[CAS_LAT];
    end

    assign sd_cke    = 1'b1;
    assign {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} = pin_q.cmd;
    assign sd_ba     = pin_q.ba;
    assign sd_a      = pin_q.a;
    assign sd_dqm    = pin_q.dqm;
    assign sd_dq_out = pin_q.dq;
    assign sd_dq_oe  = pin_q.oe;
endmodule

// File: rtl/sdram_seq.sv
module sdram_seq import sdram_seq_pkg::*; #(
    parameter int INIT_WAIT    = 20000,
    parameter int REF_INTERVAL = 1560,
    parameter int T_RCD        = 2,
    parameter int T_RAS        = 5,
    parameter int T_RC         = 7,
    parameter int T_RP         = 2,
    parameter int T_RRC        = 7,
    parameter int T_MRD        = 2,
    parameter int T_WR         = 2,
    parameter int CAS_LAT      = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DQ_W-1:0]   req_wdata,
    input  logic [LANES-1:0]  req_be,
    output logic              rd_valid,
    output logic [DQ_W-1:0]   rd_data,
    output logic              sd_cke,
    output logic              sd_cs_n,
    output logic              sd_ras_n,
    output logic              sd_cas_n,
    output logic              sd_we_n,
    output logic [BA_W-1:0]   sd_ba,
    output logic [ROW_W-1:0]  sd_a,
    output logic [LANES-1:0]  sd_dqm,
    output logic [DQ_W-1:0]   sd_dq_out,
    output logic              sd_dq_oe,
    input  logic [DQ_W-1:0]   sd_dq_in
);
    sd_bus_t bus_nxt;
    logic    ref_pending, ref_ack, init_done;

    sdram_seq_refresh #(.INTERVAL(REF_INTERVAL)) u_ref (
        .clk(clk), .rst(rst), .en(init_done), .ack(ref_ack), .pending(ref_pending)
    );

    sdram_seq_ctrl #(
        .INIT_WAIT(INIT_WAIT), .T_RCD(T_RCD), .T_RAS(T_RAS), .T_RC(T_RC),
        .T_RP(T_RP), .T_RRC(T_RRC), .T_MRD(T_MRD), .T_WR(T_WR), .CAS_LAT(CAS_LAT)
    ) u_ctrl (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be),
        .req_ready(req_ready), .ref_pending(ref_pending), .ref_ack(ref_ack),
        .init_done(init_done), .bus_nxt(bus_nxt)
    );

    sdram_seq_phy #(.CAS_LAT(CAS_LAT)) u_phy (
        .clk(clk), .rst(rst), .bus_nxt(bus_nxt), .sd_dq_in(sd_dq_in),
        .sd_cke(sd_cke), .sd_cs_n(sd_cs_n), .sd_ras_n(sd_ras_n),
        .sd_cas_n(sd_cas_n), .sd_we_n(sd_we_n), .sd_ba(sd_ba), .sd_a(sd_a),
        .sd_dqm(sd_dqm), .sd_dq_out(sd_dq_out), .sd_dq_oe(sd_dq_oe),
        .rd_valid(rd_valid), .rd_data(rd_data)
    );
endmodule

// File: rtl/sdram_seq_chk.sv
module sdram_seq_chk import sdram_seq_pkg::*; #(
    parameter int T_RCD   = 2,
    parameter int T_RC    = 7,
    parameter int T_RRC   = 7,
    parameter int CAS_LAT = 2
) (
    input logic             clk,
    input logic             rst,
    input logic             req_valid,
    input logic             req_ready,
    input logic             sd_cs_n,
    input logic             sd_ras_n,
    input logic             sd_cas_n,
    input logic             sd_we_n,
    input logic [ROW_W-1:0] sd_a,
    input logic             sd_dq_oe,
    input logic             rd_valid
);
    localparam logic [15:0] SAT = 16'hFFFF;

    logic [3:0]  pin_cmd;
    logic        is_act, is_rd, is_wr, is_ref, is_nop;
    logic [15:0] since_act, since_ref;

    assign pin_cmd = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};
    assign is_act  = (pin_cmd == CMD_ACT);
    assign is_rd   = (pin_cmd == CMD_RD);
    assign is_wr   = (pin_cmd == CMD_WR);
    assign is_ref  = (pin_cmd == CMD_REF);
    assign is_nop  = (pin_cmd == CMD_NOP) || sd_cs_n;

    always_ff @(posedge clk) begin
        if (rst) begin
            since_act <= SAT;
            since_ref <= SAT;
        end else begin
            since_act <= is_act ? 16'd1 : ((since_act == SAT) ? SAT : since_act + 16'd1);
            since_ref <= is_ref ? 16'd1 : ((since_ref == SAT) ? SAT : since_ref + 16'd1);
        end
    end

    p_rw_delay_r3: assert property (@(posedge clk) disable iff (rst)
        (is_rd || is_wr) |-> (since_act == 16'(T_RCD)));

    p_autopre_r3: assert property (@(posedge clk) disable iff (rst)
        (is_rd || is_wr) |-> sd_a[AP_BIT]);

    p_oe_write_r4: assert property (@(posedge clk) disable iff (rst)
        sd_dq_oe == is_wr);

    p_rd_latency_r5: assert property (@(posedge clk) disable iff (rst)
        rd_valid |-> $past(is_rd, CAS_LAT + 1));

    p_act_spacing_r6: assert property (@(posedge clk) disable iff (rst)
        is_act |-> (since_act >= 16'(T_RC)));

    p_ref_quiet_r8: assert property (@(posedge clk) disable iff (rst)
        !is_nop |-> (since_ref >= 16'(T_RRC)));

    p_accept_act_r9: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> is_act);

    p_ready_drop_r9: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> !req_ready);
endmodule

bind sdram_seq sdram_seq_chk #(
    .T_RCD(T_RCD), .T_RC(T_RC), .T_RRC(T_RRC), .CAS_LAT(CAS_LAT)
) u_chk (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .sd_cs_n(sd_cs_n), .sd_ras_n(sd_ras_n), .sd_cas_n(sd_cas_n),
    .sd_we_n(sd_we_n), .sd_a(sd_a), .sd_dq_oe(sd_dq_oe), .rd_valid(rd_valid)
);

// File: tb/sdram_seq_bench.sv
module sdram_seq_bench;
    localparam int INIT_WAIT = 40;
    localparam int REF_INT   = 120;
    localparam int T_RCD = 2, T_RAS = 5, T_RC = 7, T_RP = 2, T_RRC = 7;
    localparam int T_MRD = 2, T_WR = 2, CL = 2;
    localparam int ACC = 7;

    localparam logic [3:0] C_MRS = 4'b0000, C_REF = 4'b0001, C_PRE = 4'b0010;
    localparam logic [3:0] C_ACT = 4'b0011, C_WR  = 4'b0100, C_RD  = 4'b0101;
    localparam logic [3:0] C_NOP = 4'b0111;

    logic        clk = 1'b0, rst = 1'b1;
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic [22:0] req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic [1:0]  req_be = '0;
    logic        req_ready, rd_valid;
    logic [15:0] rd_data;
    logic        sd_cke, sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n, sd_dq_oe;
    logic [1:0]  sd_ba, sd_dqm;
    logic [11:0] sd_a;
    logic [15:0] sd_dq_out;
    logic [15:0] sd_dq_in = '0;

    always #5 clk = ~clk;

    sdram_seq #(
        .INIT_WAIT(INIT_WAIT), .REF_INTERVAL(REF_INT), .T_RCD(T_RCD), .T_RAS(T_RAS),
        .T_RC(T_RC), .T_RP(T_RP), .T_RRC(T_RRC), .T_MRD(T_MRD), .T_WR(T_WR), .CAS_LAT(CL)
    ) u_sdram_seq (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
        .req_be(req_be), .rd_valid(rd_valid), .rd_data(rd_data), .sd_cke(sd_cke),
        .sd_cs_n(sd_cs_n), .sd_ras_n(sd_ras_n), .sd_cas_n(sd_cas_n), .sd_we_n(sd_we_n),
        .sd_ba(sd_ba), .sd_a(sd_a), .sd_dqm(sd_dqm), .sd_dq_out(sd_dq_out),
        .sd_dq_oe(sd_dq_oe), .sd_dq_in(sd_dq_in)
    );

    int n_chk = 0, n_fail = 0;
    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, exp);
        end
    endtask

    typedef struct { bit wr; logic [22:0] addr; logic [15:0] wd; logic [1:0] be; } acc_t;
    acc_t        acc_q[$];
    logic [15:0] rd_q[$];
    int          rdcyc_q[$];
    logic [15:0] ref_mem[int];
    logic [15:0] pin_mem[int];

    function automatic logic [15:0] blank(input logic [22:0] a);
        return a[15:0] ^ 16'h5A5A;
    endfunction

    int cyc = 0;
    always @(posedge clk) begin
        if (rst) cyc <= 0;
        else     cyc <= cyc + 1;
    end

    // pin-level memory model and monitor
    logic [11:0] open_row[4];
    logic        pv[0:CL];
    logic [15:0] pd[0:CL];
    int          init_n = 0, init_cyc[4];
    logic [3:0]  init_cmd[4];
    logic [11:0] init_a[4];
    logic [1:0]  init_ba[4];
    int          last_act = -1000, last_ref = -1000, mrs_cyc = -1, ref_cnt = 0;
    acc_t        cur;
    bit          cur_ok = 0;

    always @(negedge clk) begin
        logic [3:0]  c;
        logic [15:0] rv;
        int          key;
        c  = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};
        rv = '0;
        for (int i = CL; i > 0; i--) begin
            pv[i] = pv[i-1];
            pd[i] = pd[i-1];
        end
        pv[0] = 1'b0;
        pd[0] = '0;
        if (!rst) begin
            if (c != C_NOP && init_n < 4) begin
                init_cmd[init_n] = c; init_cyc[init_n] = cyc;
                init_a[init_n] = sd_a; init_ba[init_n] = sd_ba;
                init_n++;
                if (c == C_MRS) mrs_cyc = cyc;
            end else if (c == C_REF) begin
                chk(cyc - last_act >= T_RC, "R6", "act to refresh", cyc - last_act, T_RC);
                chk((cyc - (mrs_cyc + (ref_cnt + 1) * REF_INT)) >= 1 &&
                    (cyc - (mrs_cyc + (ref_cnt + 1) * REF_INT)) <= ACC + 1,
                    "R7", "refresh lateness", cyc - (mrs_cyc + (ref_cnt + 1) * REF_INT), 1);
                ref_cnt++;
                last_ref = cyc;
            end else if (c == C_ACT) begin
                chk(cyc - last_act >= T_RC, "R6", "act spacing", cyc - last_act, T_RC);
                chk(cyc - last_ref >= T_RRC, "R8", "refresh to act", cyc - last_ref, T_RRC);
                chk(cyc - mrs_cyc >= T_MRD, "R8", "mode set to act", cyc - mrs_cyc, T_MRD);
                chk(ref_cnt == (cyc - 1 - mrs_cyc) / REF_INT, "R7", "refresh owed at act",
                    ref_cnt, (cyc - 1 - mrs_cyc) / REF_INT);
                open_row[sd_ba] = sd_a;
                cur_ok = (acc_q.size() != 0);
                chk(cur_ok, "R9", "act without request", 0, 1);
                if (cur_ok) begin
                    cur = acc_q.pop_front();
                    chk({sd_ba, sd_a} == cur.addr[22:9], "R3", "act bank/row",
                        {sd_ba, sd_a}, cur.addr[22:9]);
                end
                last_act = cyc;
            end else if (c == C_WR || c == C_RD) begin
                chk(cyc - last_act == T_RCD, "R3", "act to rw", cyc - last_act, T_RCD);
                key = {sd_ba, open_row[sd_ba], sd_a[8:0]};
                if (cur_ok) begin
                    chk((c == C_WR) == cur.wr, "R2", "rw code", c, cur.wr ? C_WR : C_RD);
                    chk({sd_ba, sd_a[10], sd_a[8:0]} == {cur.addr[22:21], 1'b1, cur.addr[8:0]},
                        "R3", "rw bank/ap/col", {sd_ba, sd_a[10], sd_a[8:0]},
                        {cur.addr[22:21], 1'b1, cur.addr[8:0]});
                end
                if (c == C_WR) begin
                    if (cur_ok) begin
                        chk(sd_dq_oe && sd_dq_out == cur.wd, "R4", "write data",
                            {sd_dq_oe, sd_dq_out}, {1'b1, cur.wd});
                        chk(sd_dqm == ~cur.be, "R4", "write mask", sd_dqm, ~cur.be);
                    end
                    rv = pin_mem.exists(key) ? pin_mem[key] : blank(23'(key));
                    if (!sd_dqm[0]) rv[7:0]  = sd_dq_out[7:0];
                    if (!sd_dqm[1]) rv[15:8] = sd_dq_out[15:8];
                    pin_mem[key] = rv;
                end else begin
                    chk(!sd_dq_oe, "R4", "oe on read", sd_dq_oe, 0);
                    pv[0] = 1'b1;
                    pd[0] = pin_mem.exists(key) ? pin_mem[key] : blank(23'(key));
                    rdcyc_q.push_back(cyc);
                end
            end
            if (rd_valid) begin
                chk(rd_q.size() != 0 && rdcyc_q.size() != 0, "R5", "unexpected rd_valid", 1, 0);
                if (rd_q.size() != 0 && rdcyc_q.size() != 0) begin
                    logic [15:0] e;
                    int          rc;
                    e  = rd_q.pop_front();
                    rc = rdcyc_q.pop_front();
                    chk(rd_data == e, "R5", "read data", rd_data, e);
                    chk(cyc - rc == CL + 1, "R5", "read latency", cyc - rc, CL + 1);
                end
            end
        end
        sd_dq_in = pv[CL] ? pd[CL] : 16'hDEAD;
    end

    // driver: called at a negative edge, returns at a negative edge
    task automatic access(input bit wr, input logic [22:0] a,
                          input logic [15:0] d, input logic [1:0] be);
        acc_t        t;
        logic [15:0] v;
        t.wr = wr; t.addr = a; t.wd = d; t.be = be;
        acc_q.push_back(t);
        v = ref_mem.exists(int'(a)) ? ref_mem[int'(a)] : blank(a);
        if (wr) begin
            if (be[0]) v[7:0]  = d[7:0];
            if (be[1]) v[15:8] = d[15:8];
            ref_mem[int'(a)] = v;
        end else begin
            rd_q.push_back(v);
        end
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d; req_be = be;
        while (!req_ready) @(negedge clk);
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    function automatic logic [22:0] mk(input int b, input int r, input int c);
        return {2'(b), 12'(r), 9'(c)};
    endfunction

    bit done = 0;
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL R9 watchdog expired actual=0x%0h expected=0x%0h", cyc, 0);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        int x;
        repeat (4) @(negedge clk);
        chk(!req_ready && !rd_valid, "R1", "reset outputs", {req_ready, rd_valid}, 0);
        chk({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} == C_NOP, "R2", "reset nop",
            {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n}, C_NOP);
        chk(sd_cke == 1'b1, "R2", "cke high", sd_cke, 1);
        rst = 1'b0;
        while (mrs_cyc < 0) begin
            chk(!req_ready, "R1", "ready during init", req_ready, 0);
            @(negedge clk);
        end
        chk(init_cmd[0] == C_PRE && init_a[0][10], "R1", "first precharge all",
            {init_cmd[0], init_a[0][10]}, {C_PRE, 1'b1});
        chk(init_cyc[0] >= INIT_WAIT, "R1", "power-up wait", init_cyc[0], INIT_WAIT);
        chk(init_cmd[1] == C_REF && init_cyc[1] - init_cyc[0] == T_RP, "R1", "refresh 1",
            init_cyc[1] - init_cyc[0], T_RP);
        chk(init_cmd[2] == C_REF && init_cyc[2] - init_cyc[1] == T_RRC, "R8", "refresh 2",
            init_cyc[2] - init_cyc[1], T_RRC);
        chk(init_cmd[3] == C_MRS && init_a[3] == 12'h020 && init_ba[3] == 2'b00, "R1",
            "mode word", init_a[3], 12'h020);
        chk(init_cyc[3] - init_cyc[2] == T_RRC, "R8", "refresh to mode", init_cyc[3] - init_cyc[2], T_RRC);

        // byte-enable patterns across all banks
        access(1, mk(0, 5, 3), 16'h1234, 2'b11);
        access(1, mk(1, 6, 4), 16'hABCD, 2'b01);
        access(1, mk(2, 7, 5), 16'h5566, 2'b10);
        access(1, mk(3, 8, 6), 16'h7788, 2'b00);
        access(0, mk(0, 5, 3), 0, 0);
        access(0, mk(1, 6, 4), 0, 0);
        access(0, mk(2, 7, 5), 0, 0);
        access(0, mk(3, 8, 6), 0, 0);
        // address extremes
        access(1, mk(3, 12'hFFF, 9'h1FF), 16'hFEED, 2'b11);
        access(1, 23'd0, 16'h0F0F, 2'b11);
        access(0, mk(3, 12'hFFF, 9'h1FF), 0, 0);
        access(0, 23'd0, 0, 0);
        // overwrite one byte then read
        access(1, 23'd0, 16'hA5C3, 2'b10);
        access(0, 23'd0, 0, 0);
        // back-to-back stream across refresh deadlines
        x = 7;
        for (int i = 0; i < 90; i++) begin
            x = x * 1103515245 + 12345;
            access(x[20], mk(x[9:8], x[30:27], x[7:4]), x[31:16], x[23:22] | 2'b01);
        end
        repeat (20) @(negedge clk);
        chk(rd_q.size() == 0 && acc_q.size() == 0, "R5", "all reads returned",
            rd_q.size() + acc_q.size(), 0);
        chk(ref_cnt >= 3, "R7", "periodic refreshes seen", ref_cnt, 3);
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule